// File: doc/BRIEF.md
# Mode-Based Peripheral Clock Gating Controller

This block decides, for every peripheral of a subsystem, whether that peripheral's clock runs. The system steps through numbered operating modes. Software sets up two banks of eight gating policies, one bank for the run-type modes and one for the low-power modes. A policy is a 16-bit mask with one enable bit per mode code. Each peripheral also has a control word. The control word picks one policy from each bank and carries a flag that stops the peripheral's clock while a debugger holds the system.

What software writes is kept apart from what the gating logic uses. A mode-transition request copies the whole software view into an active shadow and records the target mode. While debug is active, the gating logic reads the software view directly, so edits take effect without a request. When debug ends, the last captured shadow applies again. The enables are registered and are meant to drive glitch-free clock gates located elsewhere.

Top module: `ckg_top`

## Requirements
- R1: After reset, every enable is 1, the active mode is DRUN (code 3), every policy register reads 0xFFFF and every peripheral control word reads 0x0000.
- R2: Register map: addresses 0..7 hold the run policies, 8..15 the low-power policies and 16..31 the peripheral control words for peripherals 0..15. A control word has the run-policy select in bits 2:0, the low-power select in bits 6:4 and the debug-freeze flag in bit 8. Reads return the software-written value at once, even before any request.
- R3: In the run-type modes TEST=1, SAFE=2, DRUN=3 and RUN0..RUN3=4..7, a peripheral's enable is bit `mode` of the run policy its run select names.
- R4: In the low-power modes HALT0=8 and STOP0=10, a peripheral's enable is bit `mode` of the low-power policy its low-power select names.
- R5: Any other mode code (0, 9, 11..15) drives every enable to 0.
- R6: Outside debug, register writes leave the enables unchanged. A request captures the software values present in its cycle together with the target mode, and the enables reflect them at the next clock edge.
- R7: While debug is active, a peripheral whose freeze flag is set has enable 0. Outside debug, the flag has no effect.
- R8: While debug is active, the enables follow the software registers directly. A write shows on the enables two edges after it is presented, one edge for the register and one for the output.
- R9: When debug ends, the enables return to the values given by the last captured shadow and mode.
- R10: Changing the target-mode input without a request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 6 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data (software view) |
| modeReq | input | 1 | Mode-transition request, one cycle |
| reqMode | input | 4 | Target mode code, sampled with modeReq |
| dbgActive | input | 1 | Debug session in progress |
| clkEn | output | 16 | Registered clock enable per peripheral |

## Verification
The checker properties assume that modeReq is a single-cycle pulse. They also assume that dbgActive and every other input change only between clock edges and are never unknown after reset. The stability property also relies on the fact that, outside debug and without a request, nothing but a register write can reach the block. The bench drives every input on the falling edge. It holds each request and write for exactly one cycle and follows each one with an idle cycle. It changes the debug level only together with a stimulus step, so every check samples a settled output.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  localparam int MODE_W      = 4;
  localparam int DATA_W      = 16;
  localparam int RUN_SEL_LSB = 0;
  localparam int LP_SEL_LSB  = 4;
  localparam int FREEZE_BIT  = 8;

  typedef enum logic [MODE_W-1:0] {
    MODE_RESET = 4'd0,
    MODE_TEST  = 4'd1,
    MODE_SAFE  = 4'd2,
    MODE_DRUN  = 4'd3,
    MODE_RUN0  = 4'd4,
    MODE_RUN1  = 4'd5,
    MODE_RUN2  = 4'd6,
    MODE_RUN3  = 4'd7,
    MODE_HALT0 = 4'd8,
    MODE_STOP0 = 4'd10
  } ckgMode_e;

  typedef struct packed {
    logic wrRun;
    logic wrLp;
    logic wrPctl;
    logic capture;
    logic useLive;
  } ckgStrobe_t;

  function automatic logic isRunMode(logic [MODE_W-1:0] m);
    return (m >= MODE_TEST) && (m <= MODE_RUN3);
  endfunction

  function automatic logic isLpMode(logic [MODE_W-1:0] m);
    return (m == MODE_HALT0) || (m == MODE_STOP0);
  endfunction
endpackage

// File: rtl/ckg_ctrl.sv
module ckg_ctrl
  import ckg_pkg::*;
#(
  parameter int NUM_PERIPH = 16,
  parameter int NUM_POLICY = 8,
  parameter int ADDR_W     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              modeReq,
  input  logic [MODE_W-1:0] reqMode,
  input  logic              dbgActive,
  output ckgStrobe_t        strobe,
  output logic [MODE_W-1:0] evalMode
);
  localparam int LP_BASE   = NUM_POLICY;
  localparam int PCTL_BASE = 2 * NUM_POLICY;
  localparam int PCTL_END  = PCTL_BASE + NUM_PERIPH;

  logic [MODE_W-1:0] activeMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeMode <= MODE_DRUN;
    else if (modeReq) activeMode <= reqMode;
  end

  always_comb begin
    strobe.wrRun   = wrEn && (addr < ADDR_W'(LP_BASE));
    strobe.wrLp    = wrEn && (addr >= ADDR_W'(LP_BASE)) && (addr < ADDR_W'(PCTL_BASE));
    strobe.wrPctl  = wrEn && (addr >= ADDR_W'(PCTL_BASE)) && (addr < ADDR_W'(PCTL_END));
    strobe.capture = modeReq;
    strobe.useLive = modeReq || dbgActive;
    evalMode       = modeReq ? reqMode : activeMode;
  end
endmodule

// File: rtl/ckg_regs.sv
module ckg_regs
  import ckg_pkg::*;
#(
  parameter int NUM_PERIPH = 16,
  parameter int NUM_POLICY = 8,
  parameter int ADDR_W     = 6,
  parameter int SEL_W      = 3,
  parameter int POL_W      = 16,
  parameter int PCTL_W     = 7
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  ckgStrobe_t                            strobe,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [DATA_W-1:0]                     wrData,
  output logic [DATA_W-1:0]                     rdData,
  output logic [NUM_POLICY-1:0][POL_W-1:0]      evalRun,
  output logic [NUM_POLICY-1:0][POL_W-1:0]      evalLp,
  output logic [NUM_PERIPH-1:0][PCTL_W-1:0]     evalPctl
);
  localparam int LP_BASE   = NUM_POLICY;
  localparam int PCTL_BASE = 2 * NUM_POLICY;

  logic [NUM_POLICY-1:0][POL_W-1:0]  swRun, swLp, actRun, actLp;
  logic [NUM_PERIPH-1:0][PCTL_W-1:0] swPctl, actPctl;
  logic [PCTL_W-1:0]                 wrPctlVal;

  assign wrPctlVal = {wrData[FREEZE_BIT], wrData[LP_SEL_LSB +: SEL_W],
                      wrData[RUN_SEL_LSB +: SEL_W]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swRun  <= '1;
      swLp   <= '1;
      swPctl <= '0;
    end else begin
      for (int k = 0; k < NUM_POLICY; k++) begin
        if (strobe.wrRun && addr == ADDR_W'(k)) swRun[k] <= wrData[POL_W-1:0];
        if (strobe.wrLp && addr == ADDR_W'(LP_BASE + k)) swLp[k] <= wrData[POL_W-1:0];
      end
      for (int p = 0; p < NUM_PERIPH; p++) begin
        if (strobe.wrPctl && addr == ADDR_W'(PCTL_BASE + p)) swPctl[p] <= wrPctlVal;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actRun  <= '1;
      actLp   <= '1;
      actPctl <= '0;
    end else if (strobe.capture) begin
      actRun  <= swRun;
      actLp   <= swLp;
      actPctl <= swPctl;
    end
  end

  assign evalRun  = strobe.useLive ? swRun  : actRun;
  assign evalLp   = strobe.useLive ? swLp   : actLp;
  assign evalPctl = strobe.useLive ? swPctl : actPctl;

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_POLICY; k++) begin
      if (addr == ADDR_W'(k)) rdData = DATA_W'(swRun[k]);
      if (addr == ADDR_W'(LP_BASE + k)) rdData = DATA_W'(swLp[k]);
    end
    for (int p = 0; p < NUM_PERIPH; p++) begin
      if (addr == ADDR_W'(PCTL_BASE + p)) begin
        rdData[RUN_SEL_LSB +: SEL_W] = swPctl[p][SEL_W-1:0];
        rdData[LP_SEL_LSB +: SEL_W]  = swPctl[p][2*SEL_W-1:SEL_W];
        rdData[FREEZE_BIT]           = swPctl[p][2*SEL_W];
      end
    end
  end
endmodule

// File: rtl/ckg_gate.sv
module ckg_gate
  import ckg_pkg::*;
#(
  parameter int NUM_PERIPH = 16,
  parameter int NUM_POLICY = 8,
  parameter int SEL_W      = 3,
  parameter int POL_W      = 16,
  parameter int PCTL_W     = 7
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_POLICY-1:0][POL_W-1:0]  evalRun,
  input  logic [NUM_POLICY-1:0][POL_W-1:0]  evalLp,
  input  logic [NUM_PERIPH-1:0][PCTL_W-1:0] evalPctl,
  input  logic [MODE_W-1:0]                 evalMode,
  input  logic                              freezeOn,
  output logic [NUM_PERIPH-1:0]             clkEn
);
  logic [NUM_PERIPH-1:0] nextEn;
  logic runSel, lpSel;

  assign runSel = isRunMode(evalMode);
  assign lpSel  = isLpMode(evalMode);

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_periph
    logic [SEL_W-1:0] runIdx, lpIdx;
    logic             frozen;
    assign runIdx = evalPctl[p][SEL_W-1:0];
    assign lpIdx  = evalPctl[p][2*SEL_W-1:SEL_W];
    assign frozen = freezeOn && evalPctl[p][2*SEL_W];
    always_comb begin
      if (frozen)      nextEn[p] = 1'b0;
      else if (runSel) nextEn[p] = evalRun[runIdx][evalMode];
      else if (lpSel)  nextEn[p] = evalLp[lpIdx][evalMode];
      else             nextEn[p] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkEn <= '1;
    else       clkEn <= nextEn;
  end
endmodule

// File: rtl/ckg_top.sv
module ckg_top
  import ckg_pkg::*;
#(
  parameter int NUM_PERIPH = 16,
  parameter int NUM_POLICY = 8,
  parameter int ADDR_W     = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  input  logic                  modeReq,
  input  logic [MODE_W-1:0]     reqMode,
  input  logic                  dbgActive,
  output logic [NUM_PERIPH-1:0] clkEn
);
  localparam int SEL_W  = $clog2(NUM_POLICY);
  localparam int POL_W  = 1 << MODE_W;
  localparam int PCTL_W = 2 * SEL_W + 1;

  ckgStrobe_t                        strobe;
  logic [MODE_W-1:0]                 evalMode;
  logic [NUM_POLICY-1:0][POL_W-1:0]  evalRun, evalLp;
  logic [NUM_PERIPH-1:0][PCTL_W-1:0] evalPctl;

  ckg_ctrl #(.NUM_PERIPH(NUM_PERIPH), .NUM_POLICY(NUM_POLICY), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .modeReq(modeReq),
    .reqMode(reqMode), .dbgActive(dbgActive), .strobe(strobe), .evalMode(evalMode)
  );

  ckg_regs #(.NUM_PERIPH(NUM_PERIPH), .NUM_POLICY(NUM_POLICY), .ADDR_W(ADDR_W),
             .SEL_W(SEL_W), .POL_W(POL_W), .PCTL_W(PCTL_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .wrData(wrData),
    .rdData(rdData), .evalRun(evalRun), .evalLp(evalLp), .evalPctl(evalPctl)
  );

  ckg_gate #(.NUM_PERIPH(NUM_PERIPH), .NUM_POLICY(NUM_POLICY), .SEL_W(SEL_W),
             .POL_W(POL_W), .PCTL_W(PCTL_W)) u_gate (
    .clk(clk), .rstN(rstN), .evalRun(evalRun), .evalLp(evalLp), .evalPctl(evalPctl),
    .evalMode(evalMode), .freezeOn(dbgActive), .clkEn(clkEn)
  );
endmodule

// File: rtl/ckg_checker.sv
module ckg_checker
  import ckg_pkg::*;
#(
  parameter int NUM_PERIPH = 16,
  parameter int PCTL_W     = 7
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              modeReq,
  input logic [MODE_W-1:0]                 reqMode,
  input logic                              dbgActive,
  input logic [NUM_PERIPH-1:0]             clkEn,
  input logic [NUM_PERIPH-1:0][PCTL_W-1:0] evalPctl
);
  localparam int FRZ = PCTL_W - 1;

  always @(posedge clk) begin
    if (!rstN) AST_RESET_ALL_ON: assert (&clkEn); // R1
  end

  AST_UNKNOWN_MODE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(modeReq) && !isRunMode($past(reqMode)) && !isLpMode($past(reqMode)))
    |-> (clkEn == '0)); // R5

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2) && !$past(modeReq) && !$past(dbgActive) && !$past(dbgActive, 2))
    |-> $stable(clkEn)); // R6

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_frz
    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(dbgActive) && $past(evalPctl[p][FRZ])) |-> !clkEn[p]); // R7
  end
endmodule

bind ckg_top ckg_checker #(.NUM_PERIPH(NUM_PERIPH), .PCTL_W(PCTL_W)) u_ckg_checker (
  .clk(clk), .rstN(rstN), .modeReq(modeReq), .reqMode(reqMode),
  .dbgActive(dbgActive), .clkEn(clkEn), .evalPctl(evalPctl)
);

// File: tb/test_ckg_top.sv
module test_ckg_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  kind;   // 0 write, 1 request, 2 idle
    logic [5:0]  addr;
    logic [15:0] data;
    logic [3:0]  mode;
    logic        dbg;
    logic [15:0] expEn;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 18;
  localparam step_t STEPS [NSTEP] = '{
    '{2'd0, 6'd1,  16'h0020, 4'd3,  1'b0, 16'hFFFF, 4'd6},  // R6 run policy 1 write held back
    '{2'd0, 6'd16, 16'h0001, 4'd3,  1'b0, 16'hFFFF, 4'd6},  // R6
    '{2'd0, 6'd17, 16'h0021, 4'd3,  1'b0, 16'hFFFF, 4'd6},  // R6
    '{2'd1, 6'd0,  16'h0000, 4'd4,  1'b0, 16'hFFFC, 4'd3},  // R3 RUN0
    '{2'd1, 6'd0,  16'h0000, 4'd5,  1'b0, 16'hFFFF, 4'd3},  // R3 RUN1
    '{2'd0, 6'd10, 16'h0100, 4'd5,  1'b0, 16'hFFFF, 4'd6},  // R6
    '{2'd0, 6'd8,  16'h0400, 4'd5,  1'b0, 16'hFFFF, 4'd6},  // R6
    '{2'd1, 6'd0,  16'h0000, 4'd8,  1'b0, 16'h0002, 4'd4},  // R4 HALT0
    '{2'd1, 6'd0,  16'h0000, 4'd10, 1'b0, 16'hFFFD, 4'd4},  // R4 STOP0
    '{2'd1, 6'd0,  16'h0000, 4'd9,  1'b0, 16'h0000, 4'd5},  // R5
    '{2'd1, 6'd0,  16'h0000, 4'd0,  1'b0, 16'h0000, 4'd5},  // R5
    '{2'd1, 6'd0,  16'h0000, 4'd3,  1'b0, 16'hFFFC, 4'd3},  // R3 DRUN
    '{2'd2, 6'd0,  16'h0000, 4'd4,  1'b0, 16'hFFFC, 4'd10}, // R10
    '{2'd0, 6'd18, 16'h0100, 4'd4,  1'b1, 16'hFFF8, 4'd7},  // R7 freeze in debug
    '{2'd0, 6'd0,  16'h0000, 4'd4,  1'b1, 16'h0000, 4'd8},  // R8 live write
    '{2'd0, 6'd1,  16'h0008, 4'd4,  1'b1, 16'h0003, 4'd8},  // R8
    '{2'd2, 6'd0,  16'h0000, 4'd3,  1'b0, 16'hFFFC, 4'd9},  // R9 back to shadow
    '{2'd1, 6'd0,  16'h0000, 4'd3,  1'b0, 16'h0003, 4'd6}   // R6 capture, R7 freeze idle
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        modeReq = 1'b0;
  logic [3:0]  reqMode = 4'd3;
  logic        dbgActive = 1'b0;
  logic [15:0] clkEn;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ckg_top i_ckg_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .modeReq(modeReq), .reqMode(reqMode),
    .dbgActive(dbgActive), .clkEn(clkEn)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readCheck(string tag, logic [5:0] a, logic [15:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  task automatic runStep(step_t s);
    @(negedge clk);
    addr = s.addr; wrData = s.data; reqMode = s.mode; dbgActive = s.dbg;
    wrEn = (s.kind == 2'd0);
    modeReq = (s.kind == 2'd1);
    @(negedge clk);
    wrEn = 1'b0; modeReq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 enables in reset", clkEn, 16'hFFFF);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 enables after reset", clkEn, 16'hFFFF);
    readCheck("R1 run policy reset", 6'd3, 16'hFFFF);
    readCheck("R1 low-power policy reset", 6'd12, 16'hFFFF);
    readCheck("R1 control word reset", 6'd20, 16'h0000);

    for (int i = 0; i < NSTEP; i++) begin
      runStep(STEPS[i]);
      check($sformatf("R%0d step %0d", STEPS[i].req, i), clkEn, STEPS[i].expEn);
    end

    readCheck("R2 run policy 1", 6'd1, 16'h0008);
    readCheck("R2 control word 1", 6'd17, 16'h0021);
    readCheck("R2 control word 2 freeze", 6'd18, 16'h0100);
    readCheck("R2 low-power policy 2", 6'd10, 16'h0100);
    readCheck("R2 low-power policy 0", 6'd8, 16'h0400);

    runStep('{2'd1, 6'd0, 16'h0000, 4'd15, 1'b0, 16'h0000, 4'd5});
    check("R5 code 15", clkEn, 16'h0000);

    runStep('{2'd0, 6'd19, 16'h0071, 4'd15, 1'b0, 16'h0000, 4'd2});
    readCheck("R2 immediate readback", 6'd19, 16'h0071);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule